// File: doc/BRIEF.md
# DDR3 Write-Leveling Pass Sequencer

This block walks a DDR3 channel through one complete write-leveling pass for a single DIMM. A start pulse makes it stop periodic refresh and ZQ short calibration. It then programs each populated rank through its own on-die termination and mode-register commands. The target DIMM's ranks enter leveling mode, and all other ranks switch their outputs off. After a fixed settling delay it turns on the PHY's leveling termination and loads a seed delay into each of the eight byte lanes.

Next it holds the PHY training enable for a fixed window. It then reads each lane's trained delay and writes a corrected value as that lane's write-DQS delay. Last, it drops the termination, puts every rank back into normal operation, re-enables refresh and calibration, and signals completion. All waits are counted in controller clock cycles, with one cycle equal to one MEMCLK. The PHY training algorithm and the DRAM devices lie outside the block.

Every input that shapes a pass is captured on the accepted start pulse: target DIMM, rank mask, DIMM type, seed overrides and pass number. Changing these inputs later has no effect on that pass.

Top module: `wl_seq`

## Requirements
- R1: After reset, refresh is enabled (`dis_refresh_o`=0), the ZQ interval is 2 and the block is idle. When a pass starts, `dis_refresh_o`=1, `zq_interval_o`=0 and `trn_dimm_o` equal to the selected DIMM are already presented in the cycle of the first ODT or mode-register command, and they hold for every command of the pass.
- R2: Chip select c belongs to DIMM c>>1. The populated chip selects are visited in ascending order, with no cycles spent on absent ones. Each visit is one ODT strobe, then an MR1 command (`mrs_reg_o`=1), then an MR2 command (`mrs_reg_o`=2).
- R3: During preparation, every ODT strobe has `odt_wl_o`=1. MR1 carries `mrs_wl_o`=1 for ranks of the target DIMM and `mrs_qoff_o`=1 for all other ranks. MR2 carries neither bit.
- R4: During exit, the same visits are repeated with `odt_wl_o`=0, and MR1 carries neither the leveling bit nor the output-off bit.
- R5: `mrs_valid_o` stays high with unchanged rank, register and bit fields until the cycle in which `mrs_ready_i` is high.
- R6: `phy_odt_en_o` first goes high 41 cycles after the cycle in which the last preparation MR2 is accepted. If no rank is populated, it goes high 41 cycles after the start cycle.
- R7: Ten cycles with the PHY termination high pass before the first seed write. `phy_odt_en_o` falls the cycle after the last write-DQS write. The first exit command (or the restore, if no rank is populated) comes ten cycles after that fall.
- R8: Seeds are written to lanes 0..7 on eight consecutive cycles (`dly_sel_o`=0). Lane i takes byte i of `seed_ovr_i` when `seed_ovr_en_i`=1. Otherwise every lane takes a type default: 0x41 for registered (`dimm_kind_i`=1), 0x12 for SO-DIMM (2), and 0x1A for unbuffered (0 or 3).
- R9: `phy_trn_en_o` rises the cycle after the last seed write. It stays high for exactly 200 cycles, or 32 cycles when `second_pass_i`=1, with the delay port idle throughout.
- R10: A delay is gross[7:5] plus fine[4:0]. From the cycle `phy_trn_en_o` falls, lanes 0..7 are read on consecutive cycles (`dly_rd_o`=1). In each of those cycles the lane's final value is written with `dly_sel_o`=1. The final value is 0 when the seed's gross field is 0 and the trained gross field is 3; otherwise it is the trained value.
- R11: `dis_refresh_o` returns to 0 and `zq_interval_o` to 2 in the cycle after the last exit MR2 is accepted. `done_o` pulses for one cycle on the next cycle, and `busy_o` is low after it.
- R12: A start pulse or input change while `busy_o`=1 is ignored. The running pass finishes exactly as captured, and only one `done_o` pulse results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one MEMCLK per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a pass (accepted when idle) |
| second_pass_i | input | 1 | Use the short training window |
| dimm_sel_i | input | 2 | DIMM to level |
| cs_present_i | input | 8 | Populated chip-select mask |
| dimm_kind_i | input | 2 | 0 unbuffered, 1 registered, 2 SO-DIMM |
| seed_ovr_en_i | input | 1 | Use per-lane override seeds |
| seed_ovr_i | input | 64 | Override seeds, byte i for lane i |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | One-cycle completion pulse |
| dis_refresh_o | output | 1 | Auto refresh suspended |
| zq_interval_o | output | 2 | ZQ short-calibration interval |
| trn_dimm_o | output | 2 | DIMM selected for training |
| odt_set_o | output | 1 | Strobe to program one rank's ODT |
| odt_cs_o | output | 3 | Rank for the ODT strobe |
| odt_wl_o | output | 1 | 1 leveling ODT, 0 mission ODT |
| mrs_valid_o | output | 1 | Mode-register command valid |
| mrs_ready_i | input | 1 | Command accepted |
| mrs_cs_o | output | 3 | Target rank of the command |
| mrs_reg_o | output | 2 | 1 for MR1, 2 for MR2 |
| mrs_wl_o | output | 1 | MR1 write-leveling bit |
| mrs_qoff_o | output | 1 | MR1 output-off bit |
| phy_odt_en_o | output | 1 | PHY leveling termination enable |
| phy_trn_en_o | output | 1 | PHY training enable |
| dly_we_o | output | 1 | Delay write strobe |
| dly_rd_o | output | 1 | Delay read strobe (trained result) |
| dly_sel_o | output | 1 | 0 seed/training register, 1 write-DQS register |
| dly_lane_o | output | 3 | Byte lane addressed |
| dly_wdata_o | output | 8 | Delay write data |
| dly_rdata_i | input | 8 | Trained delay of the addressed lane, same cycle |

## Verification
Reading a lane's trained delay and writing its corrected write-DQS value happen in the same cycle on the delay port. The correction therefore depends on data returned combinationally in that cycle and on the seed captured at start. The bench provokes this by seeding some lanes with gross field 0 and returning trained values of gross 3, gross 2 and random values, with default and override seeds. It judges each write against a bench-side correction of the value it returned in that cycle, and it requires the read strobe to accompany every such write.

// File: rtl/wl_seq_pkg.sv
package wl_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ODT, ST_MR1, ST_MR2, ST_WAIT, ST_ON,
    ST_SEED, ST_TRN, ST_READ, ST_OFF, ST_REST, ST_DONE
  } wl_state_e;

  localparam logic [1:0] MR_ONE      = 2'd1;
  localparam logic [1:0] MR_TWO      = 2'd2;
  localparam logic [1:0] KIND_RDIMM  = 2'd1;
  localparam logic [1:0] KIND_SODIMM = 2'd2;
  localparam logic [1:0] ZQ_OFF      = 2'd0;
  localparam logic [1:0] ZQ_NORMAL   = 2'd2;
endpackage

// File: rtl/wl_next_cs.sv
module wl_next_cs #(
  parameter int NUM_CS = 8,
  parameter int CS_W   = 3
) (
  input  logic [NUM_CS-1:0] mask_i,
  input  logic [CS_W-1:0]   cur_i,
  input  logic              first_i,
  output logic              vld_o,
  output logic [CS_W-1:0]   cs_o
);
  // lowest populated rank above cur_i (or lowest overall when first_i)
  always_comb begin
    vld_o = 1'b0;
    cs_o  = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (mask_i[i] && (first_i || i > int'(cur_i))) begin
        vld_o = 1'b1;
        cs_o  = CS_W'(i);
      end
    end
  end
endmodule

// File: rtl/wl_seed_pick.sv
module wl_seed_pick
  import wl_seq_pkg::*;
#(
  parameter int          LANES  = 8,
  parameter int          DW     = 8,
  parameter logic [7:0]  SEED_R = 8'h41,
  parameter logic [7:0]  SEED_S = 8'h12,
  parameter logic [7:0]  SEED_U = 8'h1A
) (
  input  logic [1:0]          kind_i,
  input  logic                ovr_en_i,
  input  logic [LANES*DW-1:0] ovr_i,
  output logic [LANES*DW-1:0] seed_o
);
  logic [DW-1:0] dflt;

  always_comb begin
    case (kind_i)
      KIND_RDIMM:  dflt = DW'(SEED_R);
      KIND_SODIMM: dflt = DW'(SEED_S);
      default:     dflt = DW'(SEED_U);
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign seed_o[g*DW +: DW] = ovr_en_i ? ovr_i[g*DW +: DW] : dflt;
  end
endmodule

// File: rtl/wl_lane_fix.sv
module wl_lane_fix #(
  parameter int DW = 8,
  parameter int GW = 3
) (
  input  logic [DW-1:0] seed_i,
  input  logic [DW-1:0] trained_i,
  output logic [DW-1:0] final_o
);
  localparam logic [GW-1:0] GROSS_WRAP = GW'(3);

  logic wrap;
  // training slipped backwards past zero: pull the result to zero
  assign wrap    = (seed_i[DW-1 -: GW] == '0) && (trained_i[DW-1 -: GW] == GROSS_WRAP);
  assign final_o = wrap ? '0 : trained_i;
endmodule

// File: rtl/wl_seq.sv
module wl_seq
  import wl_seq_pkg::*;
#(
  parameter int         NUM_CS    = 8,
  parameter int         LANES     = 8,
  parameter int         DW        = 8,
  parameter int         WAIT_PREP = 40,
  parameter int         SETTLE    = 10,
  parameter int         TRN_LONG  = 200,
  parameter int         TRN_SHORT = 32,
  parameter logic [7:0] SEED_R    = 8'h41,
  parameter logic [7:0] SEED_S    = 8'h12,
  parameter logic [7:0] SEED_U    = 8'h1A,
  localparam int        CS_W      = $clog2(NUM_CS),
  localparam int        DIMM_W    = CS_W - 1,
  localparam int        LANE_W    = $clog2(LANES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                second_pass_i,
  input  logic [DIMM_W-1:0]   dimm_sel_i,
  input  logic [NUM_CS-1:0]   cs_present_i,
  input  logic [1:0]          dimm_kind_i,
  input  logic                seed_ovr_en_i,
  input  logic [LANES*DW-1:0] seed_ovr_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                dis_refresh_o,
  output logic [1:0]          zq_interval_o,
  output logic [DIMM_W-1:0]   trn_dimm_o,
  output logic                odt_set_o,
  output logic [CS_W-1:0]     odt_cs_o,
  output logic                odt_wl_o,
  output logic                mrs_valid_o,
  input  logic                mrs_ready_i,
  output logic [CS_W-1:0]     mrs_cs_o,
  output logic [1:0]          mrs_reg_o,
  output logic                mrs_wl_o,
  output logic                mrs_qoff_o,
  output logic                phy_odt_en_o,
  output logic                phy_trn_en_o,
  output logic                dly_we_o,
  output logic                dly_rd_o,
  output logic                dly_sel_o,
  output logic [LANE_W-1:0]   dly_lane_o,
  output logic [DW-1:0]       dly_wdata_o,
  input  logic [DW-1:0]       dly_rdata_i
);
  localparam int CNT_MAX = (TRN_LONG > WAIT_PREP) ? TRN_LONG : WAIT_PREP;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] LD_PREP  = CNT_W'(WAIT_PREP - 1);
  localparam logic [CNT_W-1:0] LD_SET   = CNT_W'(SETTLE - 1);
  localparam logic [CNT_W-1:0] LD_LONG  = CNT_W'(TRN_LONG - 1);
  localparam logic [CNT_W-1:0] LD_SHORT = CNT_W'(TRN_SHORT - 1);
  localparam logic [LANE_W-1:0] LANE_LAST = LANE_W'(LANES - 1);

  wl_state_e           state_q;
  logic                exit_q, pass2_q, dis_ref_q, odt_en_q;
  logic [1:0]          zq_q;
  logic [CS_W-1:0]     cs_q;
  logic [DIMM_W-1:0]   dimm_q;
  logic [NUM_CS-1:0]   mask_q;
  logic [LANE_W-1:0]   lane_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [LANES*DW-1:0] seed_q, seed_pick;
  logic [DW-1:0]       seed_cur, fixed;
  logic                nxt_vld, own_rank, idle;
  logic [CS_W-1:0]     nxt_cs;

  assign idle = (state_q == ST_IDLE);

  wl_next_cs #(.NUM_CS(NUM_CS), .CS_W(CS_W)) i_next_cs (
    .mask_i  (idle ? cs_present_i : mask_q),
    .cur_i   (cs_q),
    .first_i (idle || state_q == ST_OFF),
    .vld_o   (nxt_vld),
    .cs_o    (nxt_cs)
  );

  wl_seed_pick #(.LANES(LANES), .DW(DW), .SEED_R(SEED_R), .SEED_S(SEED_S),
                 .SEED_U(SEED_U)) i_seed_pick (
    .kind_i   (dimm_kind_i),
    .ovr_en_i (seed_ovr_en_i),
    .ovr_i    (seed_ovr_i),
    .seed_o   (seed_pick)
  );

  assign seed_cur = seed_q[lane_q*DW +: DW];

  wl_lane_fix #(.DW(DW), .GW(3)) i_lane_fix (
    .seed_i    (seed_cur),
    .trained_i (dly_rdata_i),
    .final_o   (fixed)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      exit_q    <= 1'b0;
      pass2_q   <= 1'b0;
      dis_ref_q <= 1'b0;
      odt_en_q  <= 1'b0;
      zq_q      <= ZQ_NORMAL;
      cs_q      <= '0;
      dimm_q    <= '0;
      mask_q    <= '0;
      lane_q    <= '0;
      cnt_q     <= '0;
      seed_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          dis_ref_q <= 1'b1;
          zq_q      <= ZQ_OFF;
          dimm_q    <= dimm_sel_i;
          mask_q    <= cs_present_i;
          pass2_q   <= second_pass_i;
          seed_q    <= seed_pick;
          exit_q    <= 1'b0;
          if (nxt_vld) begin
            cs_q    <= nxt_cs;
            state_q <= ST_ODT;
          end else begin
            cnt_q   <= LD_PREP;
            state_q <= ST_WAIT;
          end
        end
        ST_ODT: state_q <= ST_MR1;
        ST_MR1: if (mrs_ready_i) state_q <= ST_MR2;
        ST_MR2: if (mrs_ready_i) begin
          if (nxt_vld) begin
            cs_q    <= nxt_cs;
            state_q <= ST_ODT;
          end else if (!exit_q) begin
            cnt_q   <= LD_PREP;
            state_q <= ST_WAIT;
          end else begin
            dis_ref_q <= 1'b0;
            zq_q      <= ZQ_NORMAL;
            state_q   <= ST_REST;
          end
        end
        ST_WAIT: if (cnt_q == '0) begin
          odt_en_q <= 1'b1;
          cnt_q    <= LD_SET;
          state_q  <= ST_ON;
        end else cnt_q <= cnt_q - 1'b1;
        ST_ON: if (cnt_q == '0) begin
          lane_q  <= '0;
          state_q <= ST_SEED;
        end else cnt_q <= cnt_q - 1'b1;
        ST_SEED: if (lane_q == LANE_LAST) begin
          lane_q  <= '0;
          cnt_q   <= pass2_q ? LD_SHORT : LD_LONG;
          state_q <= ST_TRN;
        end else lane_q <= lane_q + 1'b1;
        ST_TRN: if (cnt_q == '0) state_q <= ST_READ;
                else cnt_q <= cnt_q - 1'b1;
        ST_READ: if (lane_q == LANE_LAST) begin
          odt_en_q <= 1'b0;
          cnt_q    <= LD_SET;
          state_q  <= ST_OFF;
        end else lane_q <= lane_q + 1'b1;
        ST_OFF: if (cnt_q == '0) begin
          exit_q <= 1'b1;
          if (nxt_vld) begin
            cs_q    <= nxt_cs;
            state_q <= ST_ODT;
          end else begin
            dis_ref_q <= 1'b0;
            zq_q      <= ZQ_NORMAL;
            state_q   <= ST_REST;
          end
        end else cnt_q <= cnt_q - 1'b1;
        ST_REST: state_q <= ST_DONE;
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign own_rank = (cs_q[CS_W-1:1] == dimm_q);

  assign busy_o        = !idle;
  assign done_o        = (state_q == ST_DONE);
  assign dis_refresh_o = dis_ref_q;
  assign zq_interval_o = zq_q;
  assign trn_dimm_o    = dimm_q;
  assign odt_set_o     = (state_q == ST_ODT);
  assign odt_cs_o      = cs_q;
  assign odt_wl_o      = !exit_q;
  assign mrs_valid_o   = (state_q == ST_MR1) || (state_q == ST_MR2);
  assign mrs_cs_o      = cs_q;
  assign mrs_reg_o     = (state_q == ST_MR1) ? MR_ONE : MR_TWO;
  assign mrs_wl_o      = (state_q == ST_MR1) && !exit_q && own_rank;
  assign mrs_qoff_o    = (state_q == ST_MR1) && !exit_q && !own_rank;
  assign phy_odt_en_o  = odt_en_q;
  assign phy_trn_en_o  = (state_q == ST_TRN);
  assign dly_we_o      = (state_q == ST_SEED) || (state_q == ST_READ);
  assign dly_rd_o      = (state_q == ST_READ);
  assign dly_sel_o     = (state_q == ST_READ);
  assign dly_lane_o    = lane_q;
  assign dly_wdata_o   = (state_q == ST_READ) ? fixed : seed_cur;

  // R1
  suspend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mrs_valid_o || odt_set_o) |-> (dis_refresh_o && zq_interval_o == ZQ_OFF));

  // R3
  wl_qoff_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrs_valid_o |-> !(mrs_wl_o && mrs_qoff_o));

  // R5
  mrs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mrs_valid_o && !mrs_ready_i) |=> (mrs_valid_o && $stable(mrs_cs_o) &&
      $stable(mrs_reg_o) && $stable(mrs_wl_o) && $stable(mrs_qoff_o)));

  // R9
  trn_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_trn_en_o |-> (phy_odt_en_o && !dly_we_o && !dly_rd_o && !mrs_valid_o));

  // R10
  rd_with_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dly_we_o && dly_sel_o) |-> (dly_rd_o && phy_odt_en_o));

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o && !dis_refresh_o && zq_interval_o == ZQ_NORMAL));

  // R12
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
endmodule

// File: tb/test_wl_seq.sv
`timescale 1ns/1ps
module test_wl_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, pass2 = 1'b0, ovr_en = 1'b0, mrs_ready = 1'b0;
  logic [1:0]  dimm_sel = '0, kind = '0;
  logic [7:0]  cs_mask = '0;
  logic [63:0] ovr = '0;
  logic        busy, done, dis_ref, odt_set, odt_wl, mrs_valid, mrs_wl, mrs_qoff;
  logic        phy_odt, phy_trn, dly_we, dly_rd, dly_sel;
  logic [1:0]  zq, trn_dimm, mrs_reg;
  logic [2:0]  odt_cs, mrs_cs, dly_lane;
  logic [7:0]  dly_wdata, dly_rdata;
  logic [7:0]  trained [8];
  int          stall_mode = 0;

  always #2 clk = ~clk;

  assign dly_rdata = trained[dly_lane];

  wl_seq i_wl_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .second_pass_i(pass2),
    .dimm_sel_i(dimm_sel), .cs_present_i(cs_mask), .dimm_kind_i(kind),
    .seed_ovr_en_i(ovr_en), .seed_ovr_i(ovr), .busy_o(busy), .done_o(done),
    .dis_refresh_o(dis_ref), .zq_interval_o(zq), .trn_dimm_o(trn_dimm),
    .odt_set_o(odt_set), .odt_cs_o(odt_cs), .odt_wl_o(odt_wl),
    .mrs_valid_o(mrs_valid), .mrs_ready_i(mrs_ready), .mrs_cs_o(mrs_cs),
    .mrs_reg_o(mrs_reg), .mrs_wl_o(mrs_wl), .mrs_qoff_o(mrs_qoff),
    .phy_odt_en_o(phy_odt), .phy_trn_en_o(phy_trn), .dly_we_o(dly_we),
    .dly_rd_o(dly_rd), .dly_sel_o(dly_sel), .dly_lane_o(dly_lane),
    .dly_wdata_o(dly_wdata), .dly_rdata_i(dly_rdata)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  // monitor state
  int cyc = 0, n_ev, n_seed, n_wr, odt_rise, odt_fall, trn_rise, trn_fall, trn_hi;
  int dis_fall, done_cyc, done_cnt, start_cyc, r1_bad, r5_bad, wr_nord;
  int ev_code [64], ev_cyc [64];
  int seed_lane [8], seed_dat [8], seed_cyc [8];
  int wr_lane [8], wr_dat [8], wr_cyc [8], wr_rd [8];
  logic [1:0] exp_dimm = '0;
  logic prev_hold = 1'b0, prev_odt = 1'b0, prev_trn = 1'b0, prev_dis = 1'b0;
  logic [7:0] prev_mrs = '0;

  task automatic clear_mon();
    n_ev = 0; n_seed = 0; n_wr = 0; odt_rise = -1; odt_fall = -1;
    trn_rise = -1; trn_fall = -1; trn_hi = 0; dis_fall = -1; done_cyc = -1;
    done_cnt = 0; start_cyc = -1; r1_bad = 0; r5_bad = 0; wr_nord = 0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (start && !busy && start_cyc < 0) start_cyc = cyc;
      if (prev_hold && !(mrs_valid && {mrs_cs, mrs_reg, mrs_wl, mrs_qoff} == prev_mrs[6:0]))
        r5_bad++;
      prev_hold = mrs_valid && !mrs_ready;
      prev_mrs  = {1'b0, mrs_cs, mrs_reg, mrs_wl, mrs_qoff};
      if ((odt_set || mrs_valid) && !(dis_ref && zq == 2'd0 && trn_dimm == exp_dimm)) r1_bad++;
      if (odt_set && n_ev < 64) begin
        ev_code[n_ev] = int'(odt_cs) * 4 + int'(odt_wl) * 2;
        ev_cyc[n_ev] = cyc; n_ev++;
      end
      if (mrs_valid && mrs_ready && n_ev < 64) begin
        ev_code[n_ev] = int'(mrs_reg) * 64 + int'(mrs_cs) * 4 + int'(mrs_wl) * 2 + int'(mrs_qoff);
        ev_cyc[n_ev] = cyc; n_ev++;
      end
      if (phy_odt && !prev_odt && odt_rise < 0) odt_rise = cyc;
      if (!phy_odt && prev_odt && odt_fall < 0) odt_fall = cyc;
      if (phy_trn && !prev_trn && trn_rise < 0) trn_rise = cyc;
      if (!phy_trn && prev_trn && trn_fall < 0) trn_fall = cyc;
      if (phy_trn) trn_hi++;
      if (!dis_ref && prev_dis && dis_fall < 0) dis_fall = cyc;
      if (dly_we && !dly_sel && n_seed < 8) begin
        seed_lane[n_seed] = int'(dly_lane); seed_dat[n_seed] = int'(dly_wdata);
        seed_cyc[n_seed] = cyc; n_seed++;
      end
      if (dly_we && dly_sel && n_wr < 8) begin
        wr_lane[n_wr] = int'(dly_lane); wr_dat[n_wr] = int'(dly_wdata);
        wr_rd[n_wr] = int'(dly_rdata); wr_cyc[n_wr] = cyc; n_wr++;
        if (!dly_rd) wr_nord++;
      end
      if (done) begin done_cnt++; if (done_cyc < 0) done_cyc = cyc; end
    end
    prev_odt = phy_odt; prev_trn = phy_trn; prev_dis = dis_ref;
  end

  always @(posedge clk) begin
    #1;
    mrs_ready = stall_mode != 0 ? ($urandom % 4 == 0) : ($urandom % 3 != 0);
  end

  function automatic logic [7:0] exp_seed(input logic [1:0] k, input logic oe,
                                          input logic [63:0] ov, input int ln);
    if (oe) return ov[ln*8 +: 8];
    case (k)
      2'd1: return 8'h41;
      2'd2: return 8'h12;
      default: return 8'h1A;
    endcase
  endfunction

  function automatic logic [7:0] fix_dly(input logic [7:0] s, input logic [7:0] t);
    return (s[7:5] == 3'd0 && t[7:5] == 3'd3) ? 8'h00 : t;
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic run_case(input logic [7:0] m, input logic [1:0] d, input logic [1:0] k,
                          input logic oe, input logic [63:0] ov, input logic p2, input bit poke);
    int n, w, j, base, nt;
    int cs_list [8];
    logic [7:0] sd;
    clear_mon();
    exp_dimm = d;
    cs_mask = m; dimm_sel = d; kind = k; ovr_en = oe; ovr = ov; pass2 = p2;
    start = 1'b1; tick(); start = 1'b0;
    if (poke) begin
      repeat (25) tick();
      start = 1'b1; dimm_sel = ~d; cs_mask = ~m; kind = k ^ 2'd1;
      ovr_en = !oe; pass2 = !p2; ovr = ~ov;
      tick(); start = 1'b0;
    end
    w = 0;
    while (done_cnt == 0 && w < 3000) begin tick(); w++; end
    repeat (6) tick();

    n = 0;
    for (int c = 0; c < 8; c++) if (m[c]) begin cs_list[n] = c; n++; end
    nt = p2 ? 32 : 200;

    chk(n_ev == 6 * n, "R2 command count", n_ev, 6 * n);
    if (n_ev == 6 * n) begin
      for (int ph = 0; ph < 2; ph++) begin
        for (j = 0; j < n; j++) begin
          int c, own, e0, e1, e2;
          c = cs_list[j];
          own = ((c >> 1) == int'(d)) ? 1 : 0;
          base = ph * 3 * n + 3 * j;
          e0 = c * 4 + (ph == 0 ? 2 : 0);
          e1 = 64 + c * 4 + (ph == 0 ? (own != 0 ? 2 : 1) : 0);
          e2 = 128 + c * 4;
          chk(ev_code[base] == e0, ph == 0 ? "R3 odt wl" : "R4 odt mission", ev_code[base], e0);
          chk(ev_code[base + 1] == e1, ph == 0 ? "R3 MR1 bits" : "R4 MR1 cleared", ev_code[base + 1], e1);
          chk(ev_code[base + 2] == e2, "R2 MR2 order", ev_code[base + 2], e2);
        end
      end
    end
    chk(r1_bad == 0, "R1 suspend during commands", r1_bad, 0);
    chk(r5_bad == 0, "R5 command hold", r5_bad, 0);

    base = (n > 0 && n_ev == 6 * n) ? ev_cyc[3 * n - 1] : start_cyc;
    chk(odt_rise - base == 41, "R6 prep wait", odt_rise - base, 41);

    chk(n_seed == 8, "R8 seed count", n_seed, 8);
    if (n_seed == 8) begin
      chk(seed_cyc[0] - odt_rise == 10, "R7 settle before seeds", seed_cyc[0] - odt_rise, 10);
      for (int i = 0; i < 8; i++) begin
        chk(seed_lane[i] == i && seed_cyc[i] == seed_cyc[0] + i, "R8 seed lane order", seed_lane[i], i);
        chk(seed_dat[i] == int'(exp_seed(k, oe, ov, i)), "R8 seed value", seed_dat[i],
            int'(exp_seed(k, oe, ov, i)));
      end
      chk(trn_rise == seed_cyc[7] + 1, "R9 train start", trn_rise, seed_cyc[7] + 1);
    end
    chk(trn_fall - trn_rise == nt, "R9 train window", trn_fall - trn_rise, nt);
    chk(trn_hi == nt, "R9 train high cycles", trn_hi, nt);

    chk(n_wr == 8, "R10 write count", n_wr, 8);
    if (n_wr == 8) begin
      chk(wr_cyc[0] == trn_fall, "R10 read start", wr_cyc[0], trn_fall);
      for (int i = 0; i < 8; i++) begin
        sd = exp_seed(k, oe, ov, i);
        chk(wr_lane[i] == i && wr_cyc[i] == wr_cyc[0] + i, "R10 lane order", wr_lane[i], i);
        chk(wr_dat[i] == int'(fix_dly(sd, trained[i])), "R10 corrected delay", wr_dat[i],
            int'(fix_dly(sd, trained[i])));
        chk(wr_rd[i] == int'(trained[i]), "R10 read data", wr_rd[i], int'(trained[i]));
      end
      chk(wr_nord == 0, "R10 read with write", wr_nord, 0);
      chk(odt_fall == wr_cyc[7] + 1, "R7 odt off", odt_fall, wr_cyc[7] + 1);
    end
    if (n > 0 && n_ev == 6 * n) begin
      chk(ev_cyc[3 * n] - odt_fall == 10, "R7 settle before exit", ev_cyc[3 * n] - odt_fall, 10);
      chk(dis_fall == ev_cyc[6 * n - 1] + 1, "R11 restore timing", dis_fall, ev_cyc[6 * n - 1] + 1);
    end else if (n == 0) begin
      chk(dis_fall - odt_fall == 10, "R7 settle before restore", dis_fall - odt_fall, 10);
    end
    chk(done_cyc == dis_fall + 1, "R11 done after restore", done_cyc, dis_fall + 1);
    chk(done_cnt == 1, poke ? "R12 single done" : "R11 single done", done_cnt, 1);
    chk(!busy && !dis_ref && zq == 2'd2, poke ? "R12 idle after pass" : "R11 idle restored",
        {busy, dis_ref, zq}, 2);
  endtask

  task automatic rand_trained(input bit hot);
    for (int i = 0; i < 8; i++) begin
      if (hot && ($urandom % 2 == 0)) trained[i] = {3'd3, 5'($urandom)};
      else trained[i] = 8'($urandom);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] ov;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 8; i++) trained[i] = '0;
    clear_mon();
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(!busy && !done && !dis_ref && zq == 2'd2 && !phy_odt && !phy_trn && !mrs_valid,
        "R1 reset state", {busy, done, dis_ref, phy_odt, phy_trn, mrs_valid}, 0);
    rst_n = 1'b1;
    tick(); tick();

    // directed: wraparound on lanes 0..3, gross 2 kept on 4..5, unbuffered default seed
    trained[0] = 8'h60; trained[1] = 8'h7F; trained[2] = 8'h6A; trained[3] = 8'h75;
    trained[4] = 8'h5F; trained[5] = 8'h40; trained[6] = 8'h1F; trained[7] = 8'h80;
    run_case(8'b0000_0101, 2'd0, 2'd0, 1'b0, 64'h0, 1'b0, 1'b0);
    // registered default seed (gross 2): gross 3 results kept
    run_case(8'b1111_1111, 2'd3, 2'd1, 1'b0, 64'h0, 1'b1, 1'b0);
    // SO-DIMM, no ranks populated
    run_case(8'h00, 2'd1, 2'd2, 1'b0, 64'h0, 1'b1, 1'b0);
    // override seeds, mixed gross 0 and gross 3
    run_case(8'b0011_0000, 2'd2, 2'd3, 1'b1, 64'h7F20_1F00_E060_1F01, 1'b0, 1'b0);
    // start poked while busy, with slow command acceptance
    stall_mode = 1;
    rand_trained(1'b1);
    run_case(8'b1001_0110, 2'd1, 2'd0, 1'b0, 64'h0, 1'b1, 1'b1);
    stall_mode = 0;

    for (int r = 0; r < 14; r++) begin
      ov = {$urandom, $urandom};
      if (r % 2 == 0) ov = ov & 64'h1F1F_1F1F_FFFF_FFFF;
      rand_trained(1'b1);
      stall_mode = (r % 5 == 0) ? 1 : 0;
      run_case(8'($urandom), 2'($urandom), 2'($urandom), 1'($urandom), ov,
               (r % 3 != 0), (r % 4 == 3));
    end
    stall_mode = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule